// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the register face of one ATA channel, reached through a byte-wide host I/O port. It holds the task-file registers: error/features, sector count, sector number, cylinder low and high, drive/head, status/command, and device control/alternate status. It also serves a fixed alternate-address register. Two drive slots sit behind the channel. Each slot reports to the block, through input pins, whether it is present and whether it is a packet device or a plain disk.

The block decodes command bytes written to the command register and updates status and error in the same clock. It requests a level interrupt from the host unless device control masks it, and drops the request when the host reads status. Every command write also produces a one-cycle completion pulse toward the media side. Soft reset is driven by edges of the reset bit in device control. The block-transfer size latched by Set Multiple is given out to the media side.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After `rst_n` is released:
  - status reads 0x00 and error reads 0x00;
  - drive/head reads 0xA0;
  - sector count and sector number read 0x01, and both cylinder bytes read 0x00;
  - device control holds 0x08, `irq` is low and `mult_count` is 1.
- R2: A write to device control (address 7) that takes bit 2 (soft reset) from 0 to 1 loads status 0x90 and error 0x01. It stores the written value with bit 1 (interrupt disable) forced to 0.
- R3: A device control write that takes bit 2 from 1 to 0 does the following:
  - clears status bit 7 (busy) and sets bit 6 (ready);
  - zeroes drive/head bits 3..0;
  - sets sector count and sector number of both slots to 0x01.
- R4: An aborted command sets status 0x41 and error 0x04 and requests an interrupt. Any command code not listed in R5 to R8 aborts.
- R5: Command 0xEC on a present disk, or 0xA1 on a present packet device, sets error 0x00 and status 0x58 and requests an interrupt. Either code on any other selected slot aborts.
- R6: The power commands 0xE0, 0xE1, 0xE2, 0xE3, 0xE6, 0x94, 0x95, 0x96, 0x97 and 0x99 set status to 0x40 and request an interrupt.
- R7: Command 0xEF clears status bits 7, 5 and 0 and sets bits 6 and 4. Commands 0x91 and 0x10 clear status bit 0 and set bits 6 and 4. All three request an interrupt and leave error unchanged.
- R8: Command 0xC6 aborts when the selected sector number exceeds MAX_MULT (16). Otherwise it behaves as follows:
  - it sets `mult_count` to the selected sector count, with 0 taken as 1;
  - it clears status bit 0, sets bit 6 and requests an interrupt.
- R9: A request raises `irq` only when device control bit 1 is 0. A read of status (address 6) lowers `irq` on the next edge. A read of alternate status (address 7) does not. A command write in the same cycle wins over the clear.
- R10: A drive/head write (address 5) stores the value ORed with 0xA0. Bit 4 selects the slot. If the newly selected slot is absent, error bit 2 and status bit 0 are set.
- R11: Address map:
  - 1 is sector count, 2 sector number, 3 cylinder low and 4 cylinder high;
  - 0 reads error, and a write to it has no effect.
  
  A write to addresses 1 to 4 updates both slots' copies. A read returns the selected slot's copy.
- R12: Address 8 always reads 0xFF. While the selected slot is absent, address 5 reads 0xA0 and addresses 0 to 7 otherwise read 0x00.
- R13: `cmd_done` is high for exactly the cycle after each command write, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| drv_present | input | 2 | Slot present flags, bit n for slot n |
| drv_packet | input | 2 | Slot is a packet device (1) or disk (0) |
| irq | output | 1 | Level interrupt request |
| cmd_done | output | 1 | One-cycle pulse after each command write |
| mult_count | output | 8 | Block size latched by Set Multiple |

## Verification
Read data follows the address combinationally, so the bench compares `rdata` inside the same cycle as the read strobe, before the edge that would apply any side effect. Register updates, `irq` and `mult_count` change on the edge that samples a write or status read. `cmd_done` is a register and is due in the cycle after the command write. The bench therefore updates its expected model at that edge and compares these outputs shortly after it, before the next stimulus is driven.

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl #(
  parameter int MAX_MULT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [1:0] drv_present,
  input  logic [1:0] drv_packet,
  output logic       irq,
  output logic       cmd_done,
  output logic [7:0] mult_count
);

  logic [7:0] status_q, error_q, ctrl_q, dh_q;
  logic [1:0][7:0] scnt_q, snum_q, cyl_lo_q, cyl_hi_q;

  logic sel;
  logic sel_present, sel_packet;
  assign sel         = dh_q[4];
  assign sel_present = drv_present[sel];
  assign sel_packet  = drv_packet[sel];

  logic raise_ok;
  assign raise_ok = ~ctrl_q[1];

  always_comb begin
    rdata = 8'h00;
    if (addr == 4'd8) rdata = 8'hFF;
    else if (!sel_present) rdata = (addr == 4'd5) ? 8'hA0 : 8'h00;
    else begin
      case (addr)
        4'd0: rdata = error_q;
        4'd1: rdata = scnt_q[sel];
        4'd2: rdata = snum_q[sel];
        4'd3: rdata = cyl_lo_q[sel];
        4'd4: rdata = cyl_hi_q[sel];
        4'd5: rdata = dh_q;
        4'd6, 4'd7: rdata = status_q;
        default: rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= 8'h00;
      error_q    <= 8'h00;
      ctrl_q     <= 8'h08;
      dh_q       <= 8'hA0;
      scnt_q     <= {2{8'h01}};
      snum_q     <= {2{8'h01}};
      cyl_lo_q   <= '0;
      cyl_hi_q   <= '0;
      irq        <= 1'b0;
      cmd_done   <= 1'b0;
      mult_count <= 8'd1;
    end else begin
      cmd_done <= 1'b0;
      if (rd_en && addr == 4'd6) irq <= 1'b0;
      if (wr_en) begin
        case (addr)
          4'd1: scnt_q   <= {2{wdata}};
          4'd2: snum_q   <= {2{wdata}};
          4'd3: cyl_lo_q <= {2{wdata}};
          4'd4: cyl_hi_q <= {2{wdata}};
          4'd5: begin
            dh_q <= wdata | 8'hA0;
            if (!drv_present[wdata[4]]) begin
              error_q[2]  <= 1'b1;
              status_q[0] <= 1'b1;
            end
          end
          4'd7: begin
            if (!ctrl_q[2] && wdata[2]) begin
              status_q <= 8'h90;
              error_q  <= 8'h01;
              ctrl_q   <= wdata & 8'hFD;
            end else begin
              if (ctrl_q[2] && !wdata[2]) begin
                status_q[7] <= 1'b0;
                status_q[6] <= 1'b1;
                dh_q[3:0]   <= 4'h0;
                scnt_q      <= {2{8'h01}};
                snum_q      <= {2{8'h01}};
              end
              ctrl_q <= wdata;
            end
          end
          4'd6: begin
            cmd_done <= 1'b1;
            case (wdata)
              8'hEC, 8'hA1: begin
                if (sel_present && (sel_packet == (wdata == 8'hA1))) begin
                  error_q  <= 8'h00;
                  status_q <= 8'h58;
                end else begin
                  error_q  <= 8'h04;
                  status_q <= 8'h41;
                end
                if (raise_ok) irq <= 1'b1;
              end
              8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
              8'h94, 8'h95, 8'h96, 8'h97, 8'h99: begin
                status_q <= 8'h40;
                if (raise_ok) irq <= 1'b1;
              end
              8'hEF: begin
                status_q <= (status_q & 8'h5E) | 8'h50;
                if (raise_ok) irq <= 1'b1;
              end
              8'h91, 8'h10: begin
                status_q <= (status_q & 8'hFE) | 8'h50;
                if (raise_ok) irq <= 1'b1;
              end
              8'hC6: begin
                if (snum_q[sel] > 8'(MAX_MULT)) begin
                  error_q  <= 8'h04;
                  status_q <= 8'h41;
                end else begin
                  mult_count <= (scnt_q[sel] == 8'd0) ? 8'd1 : scnt_q[sel];
                  status_q   <= (status_q & 8'hFE) | 8'h40;
                end
                if (raise_ok) irq <= 1'b1;
              end
              default: begin
                error_q  <= 8'h04;
                status_q <= 8'h41;
                if (raise_ok) irq <= 1'b1;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ata_taskfile_checks.sv
module ata_taskfile_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [1:0] drv_present,
  input logic [1:0] drv_packet,
  input logic       irq,
  input logic       cmd_done,
  input logic [7:0] status_q,
  input logic [7:0] ctrl_q,
  input logic [7:0] dh_q
);

  logic disk_ok;
  assign disk_ok = drv_present[dh_q[4]] && !drv_packet[dh_q[4]];

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(ctrl_q[1]));

  a_r9_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd6 && !wr_en) |=> !irq);

  a_r13_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(wr_en && addr == 4'd6));

  a_r12_alt_addr_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd8) |-> (rdata == 8'hFF));

  a_r2_reset_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd7 && wdata[2] && !ctrl_q[2]) |=> (status_q == 8'h90 && !ctrl_q[1]));

  a_r4_identify_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd6 && wdata == 8'hEC && !disk_ok) |=> (status_q == 8'h41));

  a_r10_dh_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd5) |=> (dh_q[7] && dh_q[5]));

endmodule

bind ata_taskfile_ctrl ata_taskfile_checks u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .drv_present(drv_present), .drv_packet(drv_packet),
  .irq(irq), .cmd_done(cmd_done), .status_q(status_q), .ctrl_q(ctrl_q), .dh_q(dh_q)
);

// File: tb/ata_taskfile_ctrl_test.sv
module ata_taskfile_ctrl_test;
  localparam int MAXM = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [1:0] drv_present = 2'b01, drv_packet = 2'b00;
  logic [7:0] rdata, mult_count;
  logic irq, cmd_done;

  ata_taskfile_ctrl #(.MAX_MULT(MAXM)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .drv_present(drv_present), .drv_packet(drv_packet),
    .irq(irq), .cmd_done(cmd_done), .mult_count(mult_count));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  logic [7:0] m_st, m_er, m_ct, m_dh, m_mult;
  logic [7:0] m_sc [2], m_sn [2], m_cl [2], m_ch [2];
  logic m_irq, m_done;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 8'h00; m_er = 8'h00; m_ct = 8'h08; m_dh = 8'hA0; m_mult = 8'd1;
    m_irq = 0; m_done = 0;
    for (int i = 0; i < 2; i++) begin m_sc[i] = 1; m_sn[i] = 1; m_cl[i] = 0; m_ch[i] = 0; end
  endtask

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    int s = m_dh[4];
    if (a == 8) return 8'hFF;
    if (!drv_present[s]) return (a == 5) ? 8'hA0 : 8'h00;
    case (a)
      0: return m_er;
      1: return m_sc[s];
      2: return m_sn[s];
      3: return m_cl[s];
      4: return m_ch[s];
      5: return m_dh;
      6, 7: return m_st;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_power(logic [7:0] c);
    return c inside {8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'h94, 8'h95, 8'h96, 8'h97, 8'h99};
  endfunction

  task automatic model_abort();
    m_st = 8'h41; m_er = 8'h04;
  endtask

  task automatic model_apply(bit w, bit r, logic [3:0] a, logic [7:0] d);
    int s = m_dh[4];
    bit en = !m_ct[1];
    bit req = 0;
    m_done = 0;
    if (r && a == 6) m_irq = 0;
    if (!w) return;
    case (a)
      1: begin m_sc[0] = d; m_sc[1] = d; end
      2: begin m_sn[0] = d; m_sn[1] = d; end
      3: begin m_cl[0] = d; m_cl[1] = d; end
      4: begin m_ch[0] = d; m_ch[1] = d; end
      5: begin
        m_dh = d | 8'hA0;
        if (!drv_present[d[4]]) begin m_er[2] = 1; m_st[0] = 1; end
      end
      7: begin
        if (!m_ct[2] && d[2]) begin m_st = 8'h90; m_er = 8'h01; m_ct = d & 8'hFD; end
        else begin
          if (m_ct[2] && !d[2]) begin
            m_st[7] = 0; m_st[6] = 1; m_dh[3:0] = 0;
            for (int i = 0; i < 2; i++) begin m_sc[i] = 1; m_sn[i] = 1; end
          end
          m_ct = d;
        end
      end
      6: begin
        m_done = 1; req = 1;
        if (d == 8'hEC || d == 8'hA1) begin
          if (drv_present[s] && (drv_packet[s] == (d == 8'hA1))) begin m_er = 0; m_st = 8'h58; end
          else model_abort();
        end else if (is_power(d)) m_st = 8'h40;
        else if (d == 8'hEF) m_st = (m_st & ~8'hA1) | 8'h50;
        else if (d == 8'h91 || d == 8'h10) m_st = (m_st & ~8'h01) | 8'h50;
        else if (d == 8'hC6) begin
          if (m_sn[s] > MAXM) model_abort();
          else begin
            m_mult = (m_sc[s] == 0) ? 8'd1 : m_sc[s];
            m_st = (m_st & ~8'h01) | 8'h40;
          end
        end else model_abort();
        if (req && en) m_irq = 1;
      end
      default: ;
    endcase
  endtask

  function automatic string rd_tag(logic [3:0] a);
    if (a == 8 || !drv_present[m_dh[4]]) return "R12";
    if (a >= 1 && a <= 4) return "R11";
    if (a == 5) return "R10";
    return "R4/R5/R6/R7";
  endfunction

  task automatic op(bit w, bit r, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) chk(rd_tag(a), rdata, exp_rd(a));
    @(posedge clk);
    model_apply(w, r, a, d);
    #1;
    wr_en = 0; rd_en = 0;
    #1;
    chk("R9", {7'd0, irq}, {7'd0, m_irq});
    chk("R13", {7'd0, cmd_done}, {7'd0, m_done});
    chk("R8", mult_count, m_mult);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d); op(1, 0, a, d); endtask
  task automatic rd(logic [3:0] a); op(0, 1, a, 8'h00); endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cmds [16];
    void'($urandom(32'd1234));
    cmds = '{8'hEC, 8'hA1, 8'hE0, 8'hE6, 8'h99, 8'h95, 8'hEF, 8'h91,
             8'h10, 8'hC6, 8'hC6, 8'h20, 8'h00, 8'hFF, 8'hA0, 8'hE3};
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1", {7'd0, irq}, 8'h00);
    chk("R1", mult_count, 8'd1);
    for (int a = 0; a <= 8; a++) rd(4'(a));
    // R5 identify with interrupt masked, then R9 unmasked
    wr(7, 8'h02); wr(6, 8'hEC); rd(6);
    wr(7, 8'h00); wr(6, 8'hE0); rd(7); rd(6);
    wr(6, 8'hA1); rd(0); rd(6);
    // R2/R3 soft reset edges
    wr(1, 8'h33); wr(2, 8'h44); wr(5, 8'hE5);
    wr(7, 8'h06); rd(6); rd(0); wr(7, 8'h04); rd(6);
    wr(7, 8'h00); rd(6); rd(1); rd(2); rd(5);
    // R8 set multiple
    wr(2, 8'd5); wr(1, 8'd0); wr(6, 8'hC6);
    wr(1, 8'd8); wr(6, 8'hC6);
    wr(2, 8'd16); wr(1, 8'd12); wr(6, 8'hC6);
    wr(2, 8'd17); wr(1, 8'd3); wr(6, 8'hC6); rd(6); rd(0);
    // R7 features
    wr(6, 8'hEF); rd(6); wr(6, 8'h91); rd(6);
    // R10/R12 absent slot
    wr(5, 8'h10); rd(5); rd(1); rd(6); rd(8);
    drv_present = 2'b11; drv_packet = 2'b10; rd(5); rd(0); rd(6);
    wr(6, 8'hA1); rd(6); wr(6, 8'hEC); rd(6);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int k = $urandom_range(0, 99);
      logic [3:0] a = 4'($urandom_range(0, 8));
      logic [7:0] d = 8'($urandom);
      if (k < 3) begin drv_present = 2'($urandom); drv_packet = 2'($urandom); end
      if (a == 6 && k < 80) d = cmds[$urandom_range(0, 15)];
      if (a == 7) d = d & 8'h06;
      if (a == 2 && k < 50) d = 8'($urandom_range(0, 20));
      op(k < 55, k >= 40, a, d);
    end
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule